// File: doc/BRIEF.md
# Capture, compare and PWM timer channel

This block is one timer channel built around a single 16-bit data register. A 4-bit mode field in its control byte makes it work in one of three ways. It can latch the value of an external free-running 16-bit timer when an input pin shows a chosen edge. It can compare that timer against the data register and act when they match. It can generate a pulse-width-modulated output from an external 8-bit period timer. A byte-wide register port gives software access to the data register, the control byte and a sticky event flag.

In capture mode the pin passes through a synchronizer with an edge detector. The capture event can be every falling edge, every rising edge, every 4th rising edge or every 16th rising edge. In compare mode, a match can do one of four things: drive the output high, drive it low, only raise the flag, or send out a one-cycle special-event strobe. That strobe clears the external timer and asks for a conversion start. In PWM mode the 10-bit duty value is taken from the low data byte (upper 8 bits) and two control bits (lower 2 bits). The duty value is compared against the period timer extended by its two prescale bits. The external timers and the converter are not part of this block.

Top module: `ccp_unit`

## Requirements
- R1: Address 0 reads and writes the low data byte and address 1 the high data byte. Both reset to 0.
- R2: The control byte is at address 2 and resets to 0. Bits 7:6 always read 0. Bits 5:4 (the duty fraction) and bits 3:0 (the mode) read back as written.
- R3: The event flag reads as bit 0 of address 3 and also drives `irqFlag`. Once set, it stays set until a write to address 3 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged. If a new event arrives in the same cycle as a clear, the flag stays set.
- R4: Mode 0000 turns the channel off. The output is driven low and the capture prescale counter returns to zero.
- R5: Mode 0101 captures on each rising edge of `capPin` and mode 0100 on each falling edge. A capture copies the timer into both data bytes and sets the flag. The opposite edge has no effect.
- R6: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Edges that do not reach the count leave the flag and the data bytes unchanged.
- R7: In mode 1000 a match drives the output high, and entering the mode drives it low. In mode 1001 a match drives the output low, and entering the mode drives it high. A match sets the flag in both modes.
- R8: In mode 1010 a match sets the flag and leaves the output at its previous level, both when the mode is entered and on the match.
- R9: In mode 1011 a match sets the flag and pulses `specialEvent` high for exactly one cycle. `convStart` pulses in the same cycle only while `adcEnable` is 1. The output level is unchanged.
- R10: A match is seen only in the cycle in which the timer changes to a value equal to the data register. A timer that stays at the matching value does not set the flag again after it has been cleared.
- R11: Any mode 11xx is PWM. At each period-match strobe the duty value {low byte, control bits 5:4} is copied into a shadow register and the output goes high. The output then stays high for exactly that many cycles of the 10-bit count {period timer, prescale bits}.
- R12: A duty value of 0 keeps the PWM output low for the whole period. A duty value equal to or larger than the period length keeps it high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 flag |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| timerVal | input | 16 | Value of the external free-running timer |
| periodTimer | input | 8 | Value of the external period timer |
| periodFrac | input | 2 | Prescale bits below the period timer |
| periodMatch | input | 1 | One-cycle strobe on the last count of a PWM period |
| adcEnable | input | 1 | Converter enabled; gates `convStart` |
| capPin | input | 1 | Asynchronous capture input pin |
| outPin | output | 1 | Compare / PWM output pin |
| irqFlag | output | 1 | Sticky event flag |
| specialEvent | output | 1 | One-cycle strobe that clears the external timer |
| convStart | output | 1 | One-cycle conversion-start request |

## Verification
The bench builds the channel with its default parameters: two synchronizer stages and capture prescales of 4 and 16. At these values a full 16-edge prescale window runs in a few hundred cycles, and the prescale reset can be observed partway through a 4-edge window. For PWM, the bench models the period timer with a period value of 3, so each period lasts 16 cycles. This small period makes duty values below, at and above the period length reachable in a few periods, and a scoreboard compares the high time of each period against the duty value.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int FRAC_W = 2;
  localparam int DUTY_W = BYTE_W + FRAC_W;
  localparam int MODE_W = 4;
  localparam int CTL_W  = MODE_W + FRAC_W;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  // Mode groups are decoded from bits 3:2.
  localparam logic [1:0] GRP_CAP = 2'b01;
  localparam logic [1:0] GRP_CMP = 2'b10;
  localparam logic [1:0] GRP_PWM = 2'b11;

  typedef struct packed {
    logic capLoad;
    logic flagSet;
    logic outWe;
    logic outVal;
    logic shadowLoad;
    logic specPulse;
  } ctlStrobe_t;
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinRise,
  output logic pinFall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value.
  logic [STAGES:0] chain;

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign pinRise = chain[STAGES-1] & ~chain[STAGES];
  assign pinFall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
#(
  parameter int PRESCALE_A = 4,
  parameter int PRESCALE_B = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  logic              pinRise,
  input  logic              pinFall,
  input  logic [REG_W-1:0]  dataReg,
  input  logic [REG_W-1:0]  timerVal,
  input  logic [DUTY_W-1:0] periodCnt,
  input  logic              periodMatch,
  input  logic [DUTY_W-1:0] duty,
  input  logic [DUTY_W-1:0] shadow,
  input  logic              outPin,
  output ctlStrobe_t        strobe
);
  localparam int CNT_W = $clog2(PRESCALE_B);
  localparam logic [CNT_W-1:0] LIM_A = CNT_W'(PRESCALE_A - 1);
  localparam logic [CNT_W-1:0] LIM_B = CNT_W'(PRESCALE_B - 1);

  logic [REG_W-1:0]  prevTimer;
  logic [MODE_W-1:0] prevMode;
  logic [CNT_W-1:0]  presCnt;

  logic isCap, isCmp, isPwm, modeEntered, scaled, capEvt, hit, pwmEnd;
  logic [CNT_W-1:0] presLim;

  always_comb begin
    isCap       = (mode[3:2] == GRP_CAP);
    isCmp       = (mode[3:2] == GRP_CMP);
    isPwm       = (mode[3:2] == GRP_PWM);
    modeEntered = (mode != prevMode);
    scaled      = mode[1];
    presLim     = mode[0] ? LIM_B : LIM_A;
    if (scaled) capEvt = pinRise && (presCnt == presLim);
    else        capEvt = mode[0] ? pinRise : pinFall;
    hit    = isCmp && (timerVal != prevTimer) && (timerVal == dataReg);
    pwmEnd = outPin && ((periodCnt + DUTY_W'(1)) == shadow);
  end

  always_comb begin
    strobe = '0;
    if (isCap) begin
      strobe.capLoad = capEvt;
      strobe.flagSet = capEvt;
      strobe.outWe   = 1'b1;
      strobe.outVal  = 1'b0;
    end else if (isCmp) begin
      strobe.flagSet   = hit;
      strobe.specPulse = hit && (mode[1:0] == 2'b11);
      if (!mode[1]) begin
        if (modeEntered) begin
          strobe.outWe  = 1'b1;
          strobe.outVal = mode[0];
        end else if (hit) begin
          strobe.outWe  = 1'b1;
          strobe.outVal = ~mode[0];
        end
      end
    end else if (isPwm) begin
      if (periodMatch) begin
        strobe.shadowLoad = 1'b1;
        strobe.outWe      = 1'b1;
        strobe.outVal     = (duty != '0);
      end else if (pwmEnd) begin
        strobe.outWe  = 1'b1;
        strobe.outVal = 1'b0;
      end
    end else begin
      strobe.outWe  = 1'b1;
      strobe.outVal = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTimer <= '0;
      prevMode  <= '0;
      presCnt   <= '0;
    end else begin
      prevTimer <= timerVal;
      prevMode  <= mode;
      if (!isCap || !scaled)  presCnt <= '0;
      else if (pinRise)       presCnt <= (presCnt == presLim) ? '0 : presCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic [REG_W-1:0]  timerVal,
  input  logic              adcEnable,
  input  ctlStrobe_t        strobe,
  output logic [REG_W-1:0]  dataReg,
  output logic [MODE_W-1:0] mode,
  output logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] shadow,
  output logic              outPin,
  output logic              irqFlag,
  output logic              specialEvent,
  output logic              convStart
);
  logic [BYTE_W-1:0] dataLo, dataHi;
  logic [CTL_W-1:0]  ctlBits;
  logic              wrLo, wrHi, wrCtl, wrClr;

  assign wrLo  = regWrEn && (regAddr == ADDR_LO);
  assign wrHi  = regWrEn && (regAddr == ADDR_HI);
  assign wrCtl = regWrEn && (regAddr == ADDR_CTL);
  assign wrClr = regWrEn && (regAddr == ADDR_FLAG) && regWrData[0];

  assign dataReg = {dataHi, dataLo};
  assign mode    = ctlBits[MODE_W-1:0];
  assign duty    = {dataLo, ctlBits[CTL_W-1:MODE_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLo       <= '0;
      dataHi       <= '0;
      ctlBits      <= '0;
      irqFlag      <= 1'b0;
      outPin       <= 1'b0;
      shadow       <= '0;
      specialEvent <= 1'b0;
      convStart    <= 1'b0;
    end else begin
      if (strobe.capLoad) begin
        dataLo <= timerVal[BYTE_W-1:0];
        dataHi <= timerVal[REG_W-1:BYTE_W];
      end else begin
        if (wrLo) dataLo <= regWrData;
        if (wrHi) dataHi <= regWrData;
      end
      if (wrCtl)                ctlBits <= regWrData[CTL_W-1:0];
      if (strobe.flagSet)       irqFlag <= 1'b1;
      else if (wrClr)           irqFlag <= 1'b0;
      if (strobe.outWe)         outPin  <= strobe.outVal;
      if (strobe.shadowLoad)    shadow  <= duty;
      specialEvent <= strobe.specPulse;
      convStart    <= strobe.specPulse && adcEnable;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_LO:  regRdData = dataLo;
      ADDR_HI:  regRdData = dataHi;
      ADDR_CTL: regRdData = {{(BYTE_W-CTL_W){1'b0}}, ctlBits};
      default:  regRdData = {{(BYTE_W-1){1'b0}}, irqFlag};
    endcase
  end
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE_A  = 4,
  parameter int PRESCALE_B  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [15:0] timerVal,
  input  logic [7:0]  periodTimer,
  input  logic [1:0]  periodFrac,
  input  logic        periodMatch,
  input  logic        adcEnable,
  input  logic        capPin,
  output logic        outPin,
  output logic        irqFlag,
  output logic        specialEvent,
  output logic        convStart
);
  ctlStrobe_t        strobe;
  logic              pinRise, pinFall;
  logic [REG_W-1:0]  dataReg;
  logic [MODE_W-1:0] mode;
  logic [DUTY_W-1:0] duty, shadow;

  ccp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(capPin), .pinRise(pinRise), .pinFall(pinFall)
  );

  ccp_ctrl #(.PRESCALE_A(PRESCALE_A), .PRESCALE_B(PRESCALE_B)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .pinRise(pinRise), .pinFall(pinFall),
    .dataReg(dataReg), .timerVal(timerVal), .periodCnt({periodTimer, periodFrac}),
    .periodMatch(periodMatch), .duty(duty), .shadow(shadow), .outPin(outPin),
    .strobe(strobe)
  );

  ccp_datapath u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .timerVal(timerVal),
    .adcEnable(adcEnable), .strobe(strobe), .dataReg(dataReg), .mode(mode),
    .duty(duty), .shadow(shadow), .outPin(outPin), .irqFlag(irqFlag),
    .specialEvent(specialEvent), .convStart(convStart)
  );
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWrEn,
  input logic [3:0] wrLow4,
  input logic [1:0] rdTop,
  input logic       outPin,
  input logic       irqFlag,
  input logic       specialEvent
);
  AST_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (rdTop == 2'b00)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !(regWrEn && regAddr == 2'd3 && wrLow4[0])) |=> irqFlag); // R3

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2 && wrLow4 == 4'b0000) |=> ##1 !outPin); // R4

  AST_SPECIAL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    specialEvent |-> irqFlag); // R9

  AST_SPECIAL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    specialEvent |=> !specialEvent); // R9
endmodule

bind ccp_unit ccp_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .wrLow4(regWrData[3:0]), .rdTop(regRdData[7:6]), .outPin(outPin),
  .irqFlag(irqFlag), .specialEvent(specialEvent)
);

// File: tb/ccp_unit_bench.sv
module ccp_unit_bench;
  localparam int PER = 3;
  localparam int LEN = (PER + 1) * 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [15:0] timerVal = '0;
  logic [7:0]  periodTimer;
  logic [1:0]  periodFrac;
  logic        periodMatch;
  logic        adcEnable = 1'b0;
  logic        capPin = 1'b0;
  logic        outPin, irqFlag, specialEvent, convStart;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int speCnt = 0;
  int convCnt = 0;

  logic [9:0] pcnt;
  always @(posedge clk or negedge rstN)
    if (!rstN) pcnt <= '0;
    else       pcnt <= (pcnt == 10'(LEN - 1)) ? '0 : pcnt + 10'd1;
  assign periodTimer = pcnt[9:2];
  assign periodFrac  = pcnt[1:0];
  assign periodMatch = (pcnt == 10'(LEN - 1));

  always @(posedge clk) begin
    if (rstN && specialEvent) speCnt <= speCnt + 1;
    if (rstN && convStart)    convCnt <= convCnt + 1;
  end

  ccp_unit u_ccp_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .timerVal(timerVal),
    .periodTimer(periodTimer), .periodFrac(periodFrac), .periodMatch(periodMatch),
    .adcEnable(adcEnable), .capPin(capPin), .outPin(outPin), .irqFlag(irqFlag),
    .specialEvent(specialEvent), .convStart(convStart)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard for PWM: expected high cycles per period window.
  typedef struct { string tag; int exp; } item_t;
  item_t q[$];
  int hc = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pcnt == 10'(LEN - 1)) begin
        item_t it;
        int tot;
        tot = hc + int'(outPin);
        if (q.size() > 0) begin
          it = q.pop_front();
          check(it.tag, tot, it.exp);
        end
        hc = 0;
      end else begin
        hc = hc + int'(outPin);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = int'(regRdData);
  endtask

  task automatic setTimer(input logic [15:0] v);
    @(negedge clk);
    timerVal = v;
    waitCyc(3);
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    capPin = v;
    waitCyc(6);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin(1'b1);
      pin(1'b0);
    end
  endtask

  task automatic clearFlag();
    wr(2'd3, 8'h01);
  endtask

  task automatic pwmRun(input string tag, input int d, input logic [3:0] m, input int exp);
    wr(2'd0, 8'(d >> 2));
    wr(2'd2, {2'b00, 2'(d), m});
    while (pcnt != 10'(LEN - 1)) @(negedge clk);
    @(posedge clk);
    q.push_back('{tag, exp});
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 / R2 / R3 reset state
    rd(2'd0, v); check("R1 reset low byte", v, 0);
    rd(2'd1, v); check("R1 reset high byte", v, 0);
    rd(2'd2, v); check("R2 reset control", v, 0);
    rd(2'd3, v); check("R3 reset flag", v, 0);
    check("R4 reset out", int'(outPin), 0);

    // R1 byte access
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3);
    rd(2'd0, v); check("R1 low byte readback", v, 8'h5A);
    rd(2'd1, v); check("R1 high byte readback", v, 8'hC3);

    // R2 control bits 7:6 read zero
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R2 control readback", v, 8'h3F);
    wr(2'd2, 8'h00);
    waitCyc(2);
    check("R4 off drives low", int'(outPin), 0);

    // R5 rising-edge capture
    wr(2'd2, 8'h05);
    setTimer(16'hA5C3);
    pin(1'b1);
    rd(2'd0, v); check("R5 rise capture low", v, 8'hC3);
    rd(2'd1, v); check("R5 rise capture high", v, 8'hA5);
    check("R5 rise capture flag", int'(irqFlag), 1);

    // R3 sticky flag
    wr(2'd3, 8'h00);
    rd(2'd3, v); check("R3 write zero keeps flag", v, 1);
    clearFlag();
    rd(2'd3, v); check("R3 write one clears flag", v, 0);

    // R5 falling edge ignored in rising mode
    setTimer(16'h1111);
    pin(1'b0);
    check("R5 fall ignored flag", int'(irqFlag), 0);
    rd(2'd0, v); check("R5 fall ignored data", v, 8'hC3);

    // R5 falling-edge capture
    wr(2'd2, 8'h04);
    setTimer(16'h2222);
    pin(1'b1);
    check("R5 rise ignored in fall mode", int'(irqFlag), 0);
    setTimer(16'h3C5A);
    pin(1'b0);
    check("R5 fall capture flag", int'(irqFlag), 1);
    rd(2'd0, v); check("R5 fall capture low", v, 8'h5A);
    rd(2'd1, v); check("R5 fall capture high", v, 8'h3C);
    clearFlag();

    // R6 every 4th rising edge
    wr(2'd2, 8'h06);
    setTimer(16'h0004);
    pulses(3);
    check("R6 three edges no capture", int'(irqFlag), 0);
    setTimer(16'h0444);
    pulses(1);
    check("R6 fourth edge capture", int'(irqFlag), 1);
    rd(2'd0, v); check("R6 fourth edge data", v, 8'h44);
    clearFlag();

    // R4 off resets prescaler
    pulses(2);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h06);
    pulses(3);
    check("R4 prescaler reset by off", int'(irqFlag), 0);
    pulses(1);
    check("R4 capture after prescaler reset", int'(irqFlag), 1);
    clearFlag();

    // R6 every 16th rising edge
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h07);
    pulses(15);
    check("R6 fifteen edges no capture", int'(irqFlag), 0);
    setTimer(16'h7E81);
    pulses(1);
    check("R6 sixteenth edge capture", int'(irqFlag), 1);
    rd(2'd1, v); check("R6 sixteenth edge data", v, 8'h7E);
    clearFlag();

    // R7 compare clear-on-match
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    setTimer(16'h1233);
    wr(2'd2, 8'h09);
    waitCyc(2);
    check("R7 entry of clear mode drives high", int'(outPin), 1);
    setTimer(16'h1234);
    check("R7 clear on match", int'(outPin), 0);
    check("R7 clear match flag", int'(irqFlag), 1);
    clearFlag();

    // R7 compare set-on-match
    setTimer(16'h1233);
    wr(2'd2, 8'h08);
    waitCyc(2);
    check("R7 entry of set mode drives low", int'(outPin), 0);
    setTimer(16'h1234);
    check("R7 set on match", int'(outPin), 1);
    check("R7 set match flag", int'(irqFlag), 1);

    // R8 flag-only compare
    wr(2'd2, 8'h0A);
    clearFlag();
    waitCyc(2);
    check("R8 entry keeps output", int'(outPin), 1);
    check("R10 stalled timer no flag", int'(irqFlag), 0);
    setTimer(16'h1233);
    setTimer(16'h1234);
    check("R8 match sets flag", int'(irqFlag), 1);
    check("R8 match keeps output", int'(outPin), 1);
    clearFlag();
    waitCyc(10);
    check("R10 held match no new flag", int'(irqFlag), 0);

    // R9 special event
    wr(2'd2, 8'h0B);
    adcEnable = 1'b1;
    setTimer(16'h1233);
    setTimer(16'h1234);
    check("R9 special pulse count", speCnt, 1);
    check("R9 conversion pulse count", convCnt, 1);
    check("R9 special flag", int'(irqFlag), 1);
    check("R9 output unchanged", int'(outPin), 1);
    adcEnable = 1'b0;
    setTimer(16'h1233);
    setTimer(16'h1234);
    check("R9 special pulse second", speCnt, 2);
    check("R9 conversion gated off", convCnt, 1);
    clearFlag();

    // R4 off after compare drives low
    wr(2'd2, 8'h00);
    waitCyc(2);
    check("R4 off clears output", int'(outPin), 0);

    // R11 / R12 PWM through the scoreboard
    pwmRun("R11 duty 5", 5, 4'b1100, 5);
    pwmRun("R11 duty 9 mode 1111", 9, 4'b1111, 9);
    pwmRun("R12 duty zero", 0, 4'b1100, 0);
    pwmRun("R12 duty equal period", LEN, 4'b1101, LEN);
    pwmRun("R12 duty above period", 40, 4'b1100, LEN);
    pwmRun("R11 duty 2", 2, 4'b1110, 2);

    wr(2'd2, 8'h00);
    waitCyc(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule